// File: doc/BRIEF.md
# I2C Controller Register Front-End

This block is the register side of an I2C master. A host reaches it through a simple word-addressed read/write port. A separate bus engine receives byte commands from a command queue, and its received bytes land in a receive queue. Between the two sides the block holds the control fields (core enable, fast-speed select, two queue thresholds), the SCL low, SCL high and SDA hold counts that the engine uses, an interrupt status register with a matching enable mask, queue level readback, and a busy flag mirrored from the engine.

Two status bits follow queue occupancy against programmable thresholds: command room and receive data waiting. Three more are sticky: NACK seen, arbitration lost, and receive overflow. The single interrupt line is the OR of status bits whose enable bit is set. Clearing the enable bit flushes both queues and wipes the status, so toggling it acts as a soft reset.

A host writes command words to offset 0x00, drains received bytes from 0x04, and services the interrupt by reading 0x10 and writing ones back to it.

Top module: `i2c_csr_front`

## Requirements
- R1: After reset, every readable register returns 0, `irq` is low and `cmd_valid` is low.
- R2: A write to offset 0x00 queues bits 9:0 of the write data: bit 9 = START before the byte, bit 8 = STOP after it, bits 7:0 = the byte. Entries appear on `cmd_data` with `cmd_valid` high in write order. An entry leaves the queue on a cycle where `cmd_valid` and `cmd_ready` are both high.
- R3: The command queue holds `FIFO_DEPTH` entries (default 4). A command write made while the queue is full is dropped, and the level stays at `FIFO_DEPTH`.
- R4: A byte presented with `rx_valid` high enters the receive queue. A read of offset 0x04 returns the oldest byte in bits 7:0 and removes it. A read of 0x04 with the queue empty returns 0.
- R5: A byte that arrives while the receive queue is full, with the core enabled, is dropped and latches status bit 4 (overflow).
- R6: Status bit 0 (command room) is set while enabled and the command level is at or below control bits 3:2. Status bit 1 (data waiting) is set while enabled and the receive level is above control bits 5:4, so a field value of 0 means one entry. Both bits return after being cleared as long as their condition holds.
- R7: A pulse on `eng_nack` latches status bit 2 and a pulse on `eng_arb_lost` latches status bit 3. Writing a 1 to a status bit at offset 0x10 clears it, and writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some status bit and the same bit of the enable register at 0x0C (bits 4:0) are both 1.
- R9: While control bit 0 (enable) is 0, both queues are held empty, every status bit reads 0, and command writes, received bytes and engine events are ignored.
- R10: Offset 0x18 returns the command queue level, offset 0x1C returns the receive queue level, and bit 0 of offset 0x14 returns `eng_busy`.
- R11: Control (0x08, bits 5:0), enable mask (0x0C) and the three count registers read back what was written. Control bit 0 drives `core_en`, control bit 1 drives `fast_mode`, and offsets 0x20, 0x24 and 0x28 drive `scl_lo_cnt`, `scl_hi_cnt` and `sda_hold_cnt`.
- R12: Offset 0x00 and any unmapped offset read as 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the receive queue at 0x04) |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid in the cycle of the read strobe |
| cmd_valid | output | 1 | Command queue has an entry |
| cmd_data | output | 10 | Head command: START, STOP, byte |
| cmd_ready | input | 1 | Engine takes the head command |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| eng_busy | input | 1 | Engine busy flag |
| eng_nack | input | 1 | One-cycle NACK event |
| eng_arb_lost | input | 1 | One-cycle arbitration-loss event |
| core_en | output | 1 | Core enable field |
| fast_mode | output | 1 | Fast-speed select field |
| scl_lo_cnt | output | CNT_W | SCL low count |
| scl_hi_cnt | output | CNT_W | SCL high count |
| sda_hold_cnt | output | CNT_W | SDA hold count |
| irq | output | 1 | Combined interrupt |

## Verification
The threshold logic is swept over every threshold value (0 to 3) against every queue level (0 to 4), for both queues. Each point first clears the status bit, so the sweep separates an at-or-below comparison from an above comparison, and a bit that returns from one that stays cleared. The enable mask is swept over all 32 values against a fixed status pattern with mixed ones and zeros, which catches any wrong bit pairing in the interrupt OR. Queue tests push past full and pop past empty, which separates dropped writes and zero reads from wrapped pointers, and a disable phase checks that every side input is ignored.

// File: rtl/i2c_front_pkg.sv
package i2c_front_pkg;

   // byte offsets of the register map
   localparam logic [7:0] OFS_CMD    = 8'h00;
   localparam logic [7:0] OFS_RXD    = 8'h04;
   localparam logic [7:0] OFS_CTRL   = 8'h08;
   localparam logic [7:0] OFS_IEN    = 8'h0C;
   localparam logic [7:0] OFS_ISTAT  = 8'h10;
   localparam logic [7:0] OFS_BUSY   = 8'h14;
   localparam logic [7:0] OFS_CMDLVL = 8'h18;
   localparam logic [7:0] OFS_RXLVL  = 8'h1C;
   localparam logic [7:0] OFS_SCL_LO = 8'h20;   // 0x24 high, 0x28 hold follow
   localparam int unsigned NUM_TCNT  = 3;

   // interrupt bit positions (shared by status and enable)
   localparam int unsigned IRQ_N     = 5;
   localparam int unsigned IB_TXROOM = 0;
   localparam int unsigned IB_RXDATA = 1;
   localparam int unsigned IB_NACK   = 2;
   localparam int unsigned IB_ARB    = 3;
   localparam int unsigned IB_RXOVF  = 4;

   // command word layout
   localparam int unsigned CMD_W     = 10;
   localparam int unsigned BYTE_W    = 8;

   localparam int unsigned THR_W     = 2;

   typedef struct packed {
      logic [THR_W-1:0] rx_thr;   // bits 5:4
      logic [THR_W-1:0] tx_thr;   // bits 3:2
      logic             fast;     // bit 1
      logic             en;       // bit 0
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/i2c_front_fifo.sv
module i2c_front_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             flush,
   input  logic                             push,
   input  logic [W-1:0]                     wdata,
   input  logic                             pop,
   output logic [W-1:0]                     rdata,
   output logic [$clog2(DEPTH+1)-1:0]       count
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2c_front_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [LVL_W-1:0] cnt_q;
   logic             full, empty, do_push, do_pop;

   assign full    = (cnt_q == LVL_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp_q] <= wdata;
   end

   assign rdata = empty ? '0 : mem[rp_q];
   assign count = cnt_q;

   // R3: occupancy never exceeds the depth
   p_lvl_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LVL_W'(DEPTH));

   // R3: a push into a full queue without a pop leaves it full
   p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (cnt_q == LVL_W'(DEPTH)));

   // R4: popping an empty queue leaves it empty
   p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_front_irq.sv
module i2c_front_irq
   import i2c_front_pkg::*;
#(
   parameter int unsigned LVL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [LVL_W-1:0]  cmd_lvl,
   input  logic [LVL_W-1:0]  rx_lvl,
   input  logic [THR_W-1:0]  tx_thr,
   input  logic [THR_W-1:0]  rx_thr,
   input  logic              nack_evt,
   input  logic              arb_evt,
   input  logic              rx_drop,
   input  logic [IRQ_N-1:0]  w1c,
   input  logic [IRQ_N-1:0]  ien,
   output logic [IRQ_N-1:0]  isr,
   output logic              irq
);
   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("i2c_front_irq: LVL_W must be positive");
      end
   endgenerate

   logic [IRQ_N-1:0] set_v, isr_q;

   always_comb begin
      set_v            = '0;
      set_v[IB_TXROOM] = int'(cmd_lvl) <= int'(tx_thr);
      set_v[IB_RXDATA] = int'(rx_lvl)  >  int'(rx_thr);
      set_v[IB_NACK]   = nack_evt;
      set_v[IB_ARB]    = arb_evt;
      set_v[IB_RXOVF]  = rx_drop;
   end

   // set dominates a same-cycle clear so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  isr_q <= '0;
      else if (en) isr_q <= (isr_q & ~w1c) | set_v;
      else         isr_q <= '0;
   end

   assign isr = isr_q;
   assign irq = |(isr_q & ien);

   // R6: room condition is reflected one cycle later
   p_txroom_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && int'(cmd_lvl) <= int'(tx_thr)) |=> isr_q[IB_TXROOM]);

   // R7: a NACK event while enabled is latched
   p_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && nack_evt) |=> isr_q[IB_NACK]);

   // R7: a sticky bit with no event and no clear keeps its value
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && isr_q[IB_ARB] && !w1c[IB_ARB]) |=> isr_q[IB_ARB]);

   // R9: disabled core shows no status
   p_dis_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (isr_q == '0));

endmodule

// File: rtl/i2c_csr_front.sv
module i2c_csr_front
   import i2c_front_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned FIFO_DEPTH = 4,
   parameter int unsigned CNT_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_data,
   input  logic              cmd_ready,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              eng_busy,
   input  logic              eng_nack,
   input  logic              eng_arb_lost,
   output logic              core_en,
   output logic              fast_mode,
   output logic [CNT_W-1:0]  scl_lo_cnt,
   output logic [CNT_W-1:0]  scl_hi_cnt,
   output logic [CNT_W-1:0]  sda_hold_cnt,
   output logic              irq
);
   localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (DW < 32)          begin : g_bad_dw   $error("i2c_csr_front: DW below 32");        end
      if (CNT_W > DW)       begin : g_bad_cnt  $error("i2c_csr_front: CNT_W exceeds DW");   end
      if (ADDR_W < 6)       begin : g_bad_addr $error("i2c_csr_front: ADDR_W below 6");     end
      if (FIFO_DEPTH > 16)  begin : g_bad_dep  $error("i2c_csr_front: FIFO_DEPTH too big"); end
   endgenerate

   // ---------------- decode ----------------
   logic wr_cmd, wr_ctrl, wr_ien, wr_isr, rd_rxd;
   assign wr_cmd  = reg_wr_en && (reg_addr == ADDR_W'(OFS_CMD));
   assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(OFS_CTRL));
   assign wr_ien  = reg_wr_en && (reg_addr == ADDR_W'(OFS_IEN));
   assign wr_isr  = reg_wr_en && (reg_addr == ADDR_W'(OFS_ISTAT));
   assign rd_rxd  = reg_rd_en && (reg_addr == ADDR_W'(OFS_RXD));

   // ---------------- control and enable ----------------
   ctrl_t            ctrl_q;
   logic [IRQ_N-1:0] ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (wr_ien)  ien_q  <= reg_wdata[IRQ_N-1:0];
      end
   end

   // ---------------- timing count registers ----------------
   logic [CNT_W-1:0] tcnt [NUM_TCNT];

   generate
      for (genvar g = 0; g < NUM_TCNT; g++) begin : g_tcnt
         localparam logic [7:0] OFS = OFS_SCL_LO + 8'(4 * g);
         logic [CNT_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (reg_wr_en && reg_addr == ADDR_W'(OFS)) q <= reg_wdata[CNT_W-1:0];
         end
         assign tcnt[g] = q;
      end
   endgenerate

   // ---------------- queues ----------------
   logic [LVL_W-1:0]  cmd_lvl, rx_lvl;
   logic [BYTE_W-1:0] rx_head;
   logic              flush, rx_full, rx_drop;

   assign flush   = !ctrl_q.en;
   assign rx_full = (rx_lvl == LVL_W'(FIFO_DEPTH));
   assign rx_drop = ctrl_q.en && rx_valid && rx_full;

   i2c_front_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_cmd_q (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (wr_cmd),
      .wdata (reg_wdata[CMD_W-1:0]),
      .pop   (cmd_ready),
      .rdata (cmd_data),
      .count (cmd_lvl)
   );

   i2c_front_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (rx_valid),
      .wdata (rx_byte),
      .pop   (rd_rxd),
      .rdata (rx_head),
      .count (rx_lvl)
   );

   assign cmd_valid = (cmd_lvl != '0);

   // ---------------- interrupt ----------------
   logic [IRQ_N-1:0] isr;

   i2c_front_irq #(.LVL_W(LVL_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q.en),
      .cmd_lvl  (cmd_lvl),
      .rx_lvl   (rx_lvl),
      .tx_thr   (ctrl_q.tx_thr),
      .rx_thr   (ctrl_q.rx_thr),
      .nack_evt (eng_nack),
      .arb_evt  (eng_arb_lost),
      .rx_drop  (rx_drop),
      .w1c      (wr_isr ? reg_wdata[IRQ_N-1:0] : '0),
      .ien      (ien_q),
      .isr      (isr),
      .irq      (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_RXD):          reg_rdata = DW'(rx_head);
         ADDR_W'(OFS_CTRL):         reg_rdata = DW'(ctrl_q);
         ADDR_W'(OFS_IEN):          reg_rdata = DW'(ien_q);
         ADDR_W'(OFS_ISTAT):        reg_rdata = DW'(isr);
         ADDR_W'(OFS_BUSY):         reg_rdata = DW'(eng_busy);
         ADDR_W'(OFS_CMDLVL):       reg_rdata = DW'(cmd_lvl);
         ADDR_W'(OFS_RXLVL):        reg_rdata = DW'(rx_lvl);
         ADDR_W'(OFS_SCL_LO):       reg_rdata = DW'(tcnt[0]);
         ADDR_W'(OFS_SCL_LO + 8'h4): reg_rdata = DW'(tcnt[1]);
         ADDR_W'(OFS_SCL_LO + 8'h8): reg_rdata = DW'(tcnt[2]);
         default:                   reg_rdata = '0;
      endcase
   end

   assign core_en      = ctrl_q.en;
   assign fast_mode    = ctrl_q.fast;
   assign scl_lo_cnt   = tcnt[0];
   assign scl_hi_cnt   = tcnt[1];
   assign sda_hold_cnt = tcnt[2];

   // R9: a disabled core empties both queues
   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |=> (cmd_lvl == '0 && rx_lvl == '0));

   // R5: a byte into a full receive queue latches overflow
   p_rx_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && rx_valid && rx_lvl == LVL_W'(FIFO_DEPTH)) |=> isr[IB_RXOVF]);

   // R5: a dropped byte leaves the receive level unchanged
   p_rx_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && rx_valid && !rd_rxd && rx_lvl == LVL_W'(FIFO_DEPTH)) |=> $stable(rx_lvl));

   // R2: the head command stays put until the engine takes it
   p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready && ctrl_q.en) |=> (cmd_valid && $stable(cmd_data)));

endmodule

// File: tb/tb_i2c_csr_front.sv
module tb_i2c_csr_front;
   localparam int DW = 32, AW = 8, DEPTH = 4, CW = 32;

   logic          clk = 0, rst_n = 0;
   logic          reg_wr_en = 0, reg_rd_en = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0, reg_rdata;
   logic          cmd_valid, cmd_ready = 0;
   logic [9:0]    cmd_data;
   logic          rx_valid = 0;
   logic [7:0]    rx_byte = '0;
   logic          eng_busy = 0, eng_nack = 0, eng_arb_lost = 0;
   logic          core_en, fast_mode, irq;
   logic [CW-1:0] scl_lo_cnt, scl_hi_cnt, sda_hold_cnt;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   i2c_csr_front #(.DW(DW), .ADDR_W(AW), .FIFO_DEPTH(DEPTH), .CNT_W(CW)) dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr_en = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd_en = 1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_rd_en = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rx_in(input logic [7:0] b);
      @(negedge clk); rx_valid = 1; rx_byte = b;
      @(negedge clk); rx_valid = 0;
   endtask

   task automatic pulse_nack();
      @(negedge clk); eng_nack = 1; @(negedge clk); eng_nack = 0;
   endtask

   task automatic pulse_arb();
      @(negedge clk); eng_arb_lost = 1; @(negedge clk); eng_arb_lost = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
   end

   initial begin
      logic [31:0] v;
      logic [9:0]  exp_cmd [DEPTH];
      logic [7:0]  offs [11];
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28};

      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      for (int i = 0; i < 11; i++) begin
         rd(offs[i], v);
         chk("R1 reg", v, 32'h0);
      end
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 cmd_valid", {31'b0, cmd_valid}, 0);

      // R11: control sweep and readback
      for (int c = 0; c < 64; c++) begin
         wr(8'h08, 32'(c));
         rd(8'h08, v);
         chk("R11 ctrl", v, 32'(c));
         chk("R11 core_en", {31'b0, core_en}, 32'(c & 1));
         chk("R11 fast", {31'b0, fast_mode}, 32'((c >> 1) & 1));
      end
      wr(8'h20, 32'h0000_0123); wr(8'h24, 32'hA5A5_0042); wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h15);
      rd(8'h20, v); chk("R11 scl lo", v, 32'h123);
      rd(8'h24, v); chk("R11 scl hi", v, 32'hA5A5_0042);
      rd(8'h28, v); chk("R11 hold", v, 32'hFFFF_FFFF);
      rd(8'h0C, v); chk("R11 ien", v, 32'h15);
      chk("R11 lo out", scl_lo_cnt, 32'h123);
      chk("R11 hi out", scl_hi_cnt, 32'hA5A5_0042);
      chk("R11 hold out", sda_hold_cnt, 32'hFFFF_FFFF);
      wr(8'h0C, 32'h0);

      // R12: unmapped write changes nothing, unmapped/command read 0
      wr(8'h2C, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      rd(8'h2C, v); chk("R12 unmapped", v, 0);
      rd(8'h00, v); chk("R12 cmd reads 0", v, 0);
      rd(8'h20, v); chk("R12 lo intact", v, 32'h123);
      rd(8'h0C, v); chk("R12 ien intact", v, 0);

      // R2/R3: command queue order and overflow drop
      wr(8'h08, 32'h0); wr(8'h08, 32'h1);
      for (int k = 0; k < 6; k++) begin
         logic [9:0] cw;
         cw = {(k == 0), (k == 3), 8'(8'h10 + k)};
         if (k < DEPTH) exp_cmd[k] = cw;
         wr(8'h00, {22'b0, cw});
         rd(8'h18, v);
         chk("R3 cmd level", v, 32'((k + 1 < DEPTH) ? k + 1 : DEPTH));
      end
      for (int k = 0; k < DEPTH; k++) begin
         @(negedge clk);
         chk("R2 cmd_valid", {31'b0, cmd_valid}, 1);
         chk("R2 cmd_data", {22'b0, cmd_data}, {22'b0, exp_cmd[k]});
         cmd_ready = 1;
         @(negedge clk); cmd_ready = 0;
      end
      #1 chk("R2 drained", {31'b0, cmd_valid}, 0);

      // R6: command room threshold sweep
      for (int t = 0; t < 4; t++) begin
         for (int l = 0; l <= DEPTH; l++) begin
            wr(8'h08, 32'h0);
            wr(8'h08, 32'((t << 2) | 1));
            for (int k = 0; k < l; k++) wr(8'h00, 32'(k));
            idle(2);
            wr(8'h10, 32'h1);
            idle(2);
            rd(8'h10, v);
            chk("R6 txroom", v & 1, 32'(l <= t));
         end
      end

      // R6/R10: receive data threshold sweep
      for (int t = 0; t < 4; t++) begin
         for (int l = 0; l <= DEPTH; l++) begin
            wr(8'h08, 32'h0);
            wr(8'h08, 32'((t << 4) | 1));
            for (int k = 0; k < l; k++) rx_in(8'(k));
            idle(2);
            wr(8'h10, 32'h2);
            idle(2);
            rd(8'h10, v);
            chk("R6 rxdata", (v >> 1) & 1, 32'(l > t));
            rd(8'h1C, v);
            chk("R10 rx level", v, 32'(l));
         end
      end

      // R4/R5: receive ordering, overflow, empty read
      wr(8'h08, 32'h0); wr(8'h08, 32'h1);
      for (int k = 0; k < 6; k++) rx_in(8'(8'hA0 + k));
      idle(2);
      rd(8'h10, v); chk("R5 overflow set", (v >> 4) & 1, 1);
      rd(8'h1C, v); chk("R5 level held", v, DEPTH);
      for (int k = 0; k < DEPTH; k++) begin
         rd(8'h04, v);
         chk("R4 rx byte", v, 32'(8'hA0 + k));
      end
      rd(8'h04, v); chk("R4 empty read", v, 0);
      rd(8'h1C, v); chk("R4 level zero", v, 0);
      wr(8'h10, 32'h10); idle(2);
      rd(8'h10, v); chk("R5 overflow w1c", (v >> 4) & 1, 0);

      // R7: sticky events and write-one-to-clear
      pulse_nack(); idle(2);
      rd(8'h10, v); chk("R7 nack set", (v >> 2) & 1, 1);
      wr(8'h10, 32'h0); idle(1);
      rd(8'h10, v); chk("R7 zero write", (v >> 2) & 1, 1);
      wr(8'h10, 32'h4); idle(1);
      rd(8'h10, v); chk("R7 nack clr", (v >> 2) & 1, 0);
      pulse_arb(); idle(2);
      rd(8'h10, v); chk("R7 arb set", (v >> 3) & 1, 1);
      wr(8'h10, 32'h8); idle(1);
      rd(8'h10, v); chk("R7 arb clr", (v >> 3) & 1, 0);

      // R8: enable mask sweep against status 0x17
      wr(8'h08, 32'h0);
      wr(8'h08, 32'h31);          // enable, tx thr 0, rx thr 3
      for (int k = 0; k < 5; k++) rx_in(8'(k));
      pulse_nack(); idle(2);
      rd(8'h10, v); chk("R8 status", v, 32'h17);
      for (int m = 0; m < 32; m++) begin
         wr(8'h0C, 32'(m));
         #1 chk("R8 irq", {31'b0, irq}, 32'((m & 32'h17) != 0));
      end
      wr(8'h0C, 32'h0);

      // R9: disable flushes and ignores inputs
      wr(8'h00, 32'h55);
      wr(8'h08, 32'h0); idle(2);
      rd(8'h18, v); chk("R9 cmd flushed", v, 0);
      rd(8'h1C, v); chk("R9 rx flushed", v, 0);
      rd(8'h10, v); chk("R9 status clear", v, 0);
      wr(8'h00, 32'h66);
      rx_in(8'h77);
      pulse_nack(); pulse_arb(); idle(2);
      rd(8'h18, v); chk("R9 cmd ignored", v, 0);
      rd(8'h1C, v); chk("R9 rx ignored", v, 0);
      rd(8'h10, v); chk("R9 events ignored", v, 0);
      chk("R9 cmd_valid", {31'b0, cmd_valid}, 0);

      // R10: busy mirror
      eng_busy = 1;
      rd(8'h14, v); chk("R10 busy 1", v, 1);
      eng_busy = 0;
      rd(8'h14, v); chk("R10 busy 0", v, 0);

      summary();
   end
endmodule